// File: doc/BRIEF.md
# File-Register Byte Operation Executor

This block is the execute stage for two byte-wide instructions of a small accumulator core. The first rotates a data-memory byte right by one place without a carry. The second fills a data-memory byte with all ones. Each instruction word is decoded into an opcode, a destination select, a bank-mode bit and an 8-bit file offset. The offset is then turned into a 12-bit data address in one of three ways: through the bank select input, through the fixed access window, or by adding it to a pointer input when extended mode is on.

Work proceeds in a free-running loop of four phases. The instruction word and the addressing inputs are captured at the end of the first phase. The operand is read at the end of the second, the result is formed at the end of the third, and the result is committed at the end of the fourth. The byte array of data memory sits inside the block. A separate load port lets neighbouring logic deposit bytes into it.

Top module: `frop_exec`

## Requirements
- R1: After reset `phase_o` is 0, and it then steps 0,1,2,3,0 on successive clock edges. `instr_i`, `ext_mode_i`, `bsr_i` and `ptr_i` are sampled on the edge that ends phase 0.
- R2: While reset is asserted, and right after it is released, `wreg_o`, `flag_n_o` and `flag_z_o` read 0.
- R3: The word `0100 00da ffff ffff` (bit 9 = d, bit 8 = a, bits 7:0 = f) rotates the addressed byte right by one: bit n moves to bit n-1 and old bit 0 becomes bit 7 (D7h gives EBh). No carry takes part.
- R4: For the rotate, d=0 places the result in the working register and leaves memory untouched. d=1 writes the result back to memory and leaves the working register untouched.
- R5: The rotate sets N to bit 7 of the result and sets Z when the result is 00h. This holds for both values of d.
- R6: The word `0110 100a ffff ffff` writes FFh to the addressed byte. The working register and both flags stay unchanged.
- R7: With a=1 the address is {bsr_i, f}, whatever the state of `ext_mode_i`.
- R8: With a=0, and with either `ext_mode_i` low or f at 60h or above, the address is {0h, f} for f below 60h and {Fh, f} for f of 60h and above. `bsr_i` has no effect on this path.
- R9: With a=0, `ext_mode_i` high and f at 5Fh or below, the address is `ptr_i` + f, taken modulo 4096.
- R10: Any other instruction word writes nothing to the working register, the flags or memory.
- R11: A load with `ld_en_i` high stores `ld_data_i` at `ld_addr_i` on the clock edge. If an instruction commits to the same address on the same edge, the instruction's value is kept.
- R12: The working register and the flags change only on the edge that ends phase 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 16 | Instruction word, sampled at the end of phase 0 |
| ext_mode_i | input | 1 | Enables pointer-relative addressing for low offsets when a=0 |
| bsr_i | input | 4 | Bank select, upper address bits when a=1 |
| ptr_i | input | 12 | Base pointer for pointer-relative addressing |
| ld_en_i | input | 1 | Load port write enable |
| ld_addr_i | input | 12 | Load port address |
| ld_data_i | input | 8 | Load port data |
| phase_o | output | 2 | Current phase, 0 to 3 |
| wreg_o | output | 8 | Working register |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |

## Verification
Some behaviour is checked on every clock by the assertions. These cover the phase stepping, the rule that the working register and flags hold outside the final phase, flag consistency after a rotate into the working register, silence after a fill or an unknown word, and the bank bits of the captured address in bank mode. Other behaviour can only be shown by the bench's scenarios, because it depends on which byte was read and where a result landed: the three address paths and their 5Fh/60h boundary, write-back into memory with d=1, pointer wraparound, the load-versus-commit collision, and the fact that memory is untouched after unknown words. The bench reads these back through later rotates into the working register and compares them against its own model.

// File: rtl/frop_pkg.sv
package frop_pkg;
  localparam int FADDR_W = 8;

  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ROTR = 2'd1,
    OP_FILL = 2'd2
  } op_e;

  typedef struct packed {
    op_e                op;
    logic               to_file;
    logic               use_bank;
    logic [FADDR_W-1:0] offs;
  } dec_t;
endpackage

// File: rtl/frop_decode.sv
module frop_decode
  import frop_pkg::*;
#(
  parameter int INSTR_W = 16
) (
  input  logic [INSTR_W-1:0] instr_i,
  output dec_t               dec_o
);
  localparam logic [5:0] ROTR_CODE = 6'b010000;
  localparam logic [6:0] FILL_CODE = 7'b0110100;

  always_comb begin
    dec_o.op       = OP_NONE;
    dec_o.to_file  = instr_i[9];
    dec_o.use_bank = instr_i[8];
    dec_o.offs     = instr_i[FADDR_W-1:0];
    if (instr_i[INSTR_W-1 -: 6] == ROTR_CODE) begin
      dec_o.op = OP_ROTR;
    end else if (instr_i[INSTR_W-1 -: 7] == FILL_CODE) begin
      dec_o.op      = OP_FILL;
      dec_o.to_file = 1'b1;
    end
  end
endmodule

// File: rtl/frop_addr_sel.sv
module frop_addr_sel
  import frop_pkg::*;
#(
  parameter int          ADDR_W  = 12,
  parameter logic [7:0]  IDX_MAX = 8'h5F
) (
  input  logic [FADDR_W-1:0]        offs_i,
  input  logic                      use_bank_i,
  input  logic                      ext_mode_i,
  input  logic [ADDR_W-FADDR_W-1:0] bsr_i,
  input  logic [ADDR_W-1:0]         ptr_i,
  output logic [ADDR_W-1:0]         addr_o
);
  localparam int BANK_W = ADDR_W - FADDR_W;

  logic indexed;
  logic low_half;

  always_comb begin
    low_half = (offs_i <= IDX_MAX);
    indexed  = !use_bank_i && ext_mode_i && low_half;
    if (use_bank_i) begin
      addr_o = {bsr_i, offs_i};
    end else if (indexed) begin
      addr_o = ptr_i + {{BANK_W{1'b0}}, offs_i};
    end else if (low_half) begin
      addr_o = {{BANK_W{1'b0}}, offs_i};
    end else begin
      addr_o = {{BANK_W{1'b1}}, offs_i};
    end
  end
endmodule

// File: rtl/frop_alu.sv
module frop_alu
  import frop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] opnd_i,
  output logic [DATA_W-1:0] res_o,
  output logic              neg_o,
  output logic              zero_o
);
  always_comb begin
    unique case (op_i)
      OP_ROTR: res_o = {opnd_i[0], opnd_i[DATA_W-1:1]};
      OP_FILL: res_o = {DATA_W{1'b1}};
      default: res_o = opnd_i;
    endcase
    neg_o  = res_o[DATA_W-1];
    zero_o = (res_o == '0);
  end
endmodule

// File: rtl/frop_ram.sv
module frop_ram #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/frop_exec.sv
module frop_exec
  import frop_pkg::*;
#(
  parameter int         ADDR_W  = 12,
  parameter int         DATA_W  = 8,
  parameter int         INSTR_W = 16,
  parameter logic [7:0] IDX_MAX = 8'h5F
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [INSTR_W-1:0]        instr_i,
  input  logic                      ext_mode_i,
  input  logic [ADDR_W-FADDR_W-1:0] bsr_i,
  input  logic [ADDR_W-1:0]         ptr_i,
  input  logic                      ld_en_i,
  input  logic [ADDR_W-1:0]         ld_addr_i,
  input  logic [DATA_W-1:0]         ld_data_i,
  output logic [1:0]                phase_o,
  output logic [DATA_W-1:0]         wreg_o,
  output logic                      flag_n_o,
  output logic                      flag_z_o
);
  localparam int BANK_W = ADDR_W - FADDR_W;

  phase_e            phase_q, phase_d;
  dec_t              dec_c, dec_q;
  logic [ADDR_W-1:0] addr_c, addr_q;
  logic [DATA_W-1:0] opnd_q, res_c, res_q, rd_data;
  logic              neg_c, zero_c, neg_q, zero_q;
  logic [DATA_W-1:0] wreg_q, wreg_d;
  logic              n_q, n_d, z_q, z_d;
  logic              en_dec, en_rd, en_proc, en_wr;
  logic              w_we, f_we, m_we;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_waddr;
  logic [DATA_W-1:0] ram_wdata;

  frop_decode #(.INSTR_W(INSTR_W)) u_dec (
    .instr_i (instr_i),
    .dec_o   (dec_c)
  );

  frop_addr_sel #(.ADDR_W(ADDR_W), .IDX_MAX(IDX_MAX)) u_addr (
    .offs_i     (dec_c.offs),
    .use_bank_i (dec_c.use_bank),
    .ext_mode_i (ext_mode_i),
    .bsr_i      (bsr_i),
    .ptr_i      (ptr_i),
    .addr_o     (addr_c)
  );

  frop_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i   (dec_q.op),
    .opnd_i (opnd_q),
    .res_o  (res_c),
    .neg_o  (neg_c),
    .zero_o (zero_c)
  );

  frop_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk     (clk),
    .we_i    (ram_we),
    .waddr_i (ram_waddr),
    .wdata_i (ram_wdata),
    .raddr_i (addr_q),
    .rdata_o (rd_data)
  );

  // phase enables and commit decisions
  always_comb begin
    phase_d = phase_e'(phase_q + 2'd1);
    en_dec  = (phase_q == PH_Q1);
    en_rd   = (phase_q == PH_Q2);
    en_proc = (phase_q == PH_Q3);
    en_wr   = (phase_q == PH_Q4);
    w_we    = en_wr && (dec_q.op == OP_ROTR) && !dec_q.to_file;
    f_we    = en_wr && (dec_q.op == OP_ROTR);
    m_we    = en_wr && (dec_q.op != OP_NONE) && dec_q.to_file;
    wreg_d  = w_we ? res_q : wreg_q;
    n_d     = f_we ? neg_q : n_q;
    z_d     = f_we ? zero_q : z_q;
  end

  // memory write port: commit wins over the load port
  always_comb begin
    ram_we    = m_we || ld_en_i;
    ram_waddr = m_we ? addr_q : ld_addr_i;
    ram_wdata = m_we ? res_q : ld_data_i;
  end

  // control state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_Q1;
      dec_q   <= '{op: OP_NONE, to_file: 1'b0, use_bank: 1'b0, offs: '0};
      wreg_q  <= '0;
      n_q     <= 1'b0;
      z_q     <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (en_dec) begin
        dec_q <= dec_c;
      end
      wreg_q <= wreg_d;
      n_q    <= n_d;
      z_q    <= z_d;
    end
  end

  // datapath registers, not reset
  always_ff @(posedge clk) begin
    if (en_dec) begin
      addr_q <= addr_c;
    end
    if (en_rd) begin
      opnd_q <= rd_data;
    end
    if (en_proc) begin
      res_q  <= res_c;
      neg_q  <= neg_c;
      zero_q <= zero_c;
    end
  end

  assign phase_o  = phase_q;
  assign wreg_o   = wreg_q;
  assign flag_n_o = n_q;
  assign flag_z_o = z_q;

  // R1: phases advance by one each edge
  a_r1_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (phase_q == phase_e'($past(phase_q) + 2'd1)));

  // R12: working register holds outside the commit phase
  a_r12_wreg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_Q4) |=> $stable(wreg_q));

  // R12: flags hold outside the commit phase
  a_r12_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_Q4) |=> $stable({n_q, z_q}));

  // R5: rotate into the working register leaves consistent flags
  a_r5_flags_match: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && dec_q.op == OP_ROTR && !dec_q.to_file)
      |=> ((z_q == (wreg_q == '0)) && (n_q == wreg_q[DATA_W-1])));

  // R4: rotate back to memory leaves the working register alone
  a_r4_file_dest_keeps_w: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && dec_q.op == OP_ROTR && dec_q.to_file) |=> $stable(wreg_q));

  // R6: fill touches neither working register nor flags
  a_r6_fill_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && dec_q.op == OP_FILL) |=> $stable({wreg_q, n_q, z_q}));

  // R10: unknown word commits nothing
  a_r10_none_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && dec_q.op == OP_NONE) |=> ($stable({wreg_q, n_q, z_q}) && (ram_waddr == ld_addr_i)));

  // R7: bank mode takes the upper address bits from the bank select input
  a_r7_bank_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (en_dec && instr_i[8]) |=> (addr_q[ADDR_W-1 -: BANK_W] == $past(bsr_i)));
endmodule

// File: tb/frop_exec_tb.sv
module frop_exec_tb;
  localparam int AW = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr_i = 16'h0000;
  logic        ext_mode_i = 1'b0;
  logic [3:0]  bsr_i = 4'h0;
  logic [11:0] ptr_i = 12'h000;
  logic        ld_en_i = 1'b0;
  logic [11:0] ld_addr_i = 12'h000;
  logic [7:0]  ld_data_i = 8'h00;
  logic [1:0]  phase_o;
  logic [7:0]  wreg_o;
  logic        flag_n_o, flag_z_o;

  frop_exec u_dut (
    .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .ext_mode_i(ext_mode_i),
    .bsr_i(bsr_i), .ptr_i(ptr_i), .ld_en_i(ld_en_i), .ld_addr_i(ld_addr_i),
    .ld_data_i(ld_data_i), .phase_o(phase_o), .wreg_o(wreg_o),
    .flag_n_o(flag_n_o), .flag_z_o(flag_z_o)
  );

  always #10 clk = ~clk;

  typedef struct {
    logic [7:0] w;
    logic       n;
    logic       z;
    string      tag;
  } item_t;

  item_t      sb_q[$];
  logic [7:0] ref_mem [1 << AW];
  logic [7:0] ref_w;
  logic       ref_n, ref_z;
  int         n_cmp = 0;
  int         n_bad = 0;
  logic       armed = 1'b0;
  logic [1:0] prev_ph = 2'd0;
  logic       finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // monitor: arm once an instruction is in flight, compare at its retirement
  always @(negedge clk) begin
    if (rst_n) begin
      if (phase_o == 2'd1 && sb_q.size() > 0) armed <= 1'b1;
      if (armed && prev_ph == 2'd3 && phase_o == 2'd0) begin
        item_t it;
        it = sb_q.pop_front();
        chk({it.tag, " W"}, 32'(wreg_o), 32'(it.w));
        chk({it.tag, " N"}, 32'(flag_n_o), 32'(it.n));
        chk({it.tag, " Z"}, 32'(flag_z_o), 32'(it.z));
        armed <= (sb_q.size() > 0);
      end
      prev_ph <= phase_o;
    end
  end

  task automatic wait_q1();
    forever begin
      @(posedge clk); #1;
      if (phase_o == 2'd0) break;
    end
  endtask

  task automatic load(input logic [11:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    ld_en_i = 1'b1; ld_addr_i = a; ld_data_i = d;
    @(posedge clk); #1;
    ld_en_i = 1'b0;
    ref_mem[a] = d;
  endtask

  function automatic logic [11:0] ref_addr(input logic [15:0] ins);
    logic [7:0] f;
    f = ins[7:0];
    if (ins[8]) return {bsr_i, f};
    if (ext_mode_i && f <= 8'h5F) return ptr_i + {4'h0, f};
    if (f < 8'h60) return {4'h0, f};
    return {4'hF, f};
  endfunction

  // driver: model the instruction, push the expectation, run it
  task automatic issue(input logic [15:0] ins, input string tag,
                       input logic coll = 1'b0, input logic [7:0] coll_d = 8'h00);
    logic [11:0] ea;
    logic [7:0]  r;
    logic [7:0]  w_before;
    item_t       it;
    wait_q1();
    ea = ref_addr(ins);
    if (ins[15:10] == 6'b010000) begin
      r = {ref_mem[ea][0], ref_mem[ea][7:1]};
      if (ins[9]) ref_mem[ea] = r; else ref_w = r;
      ref_n = r[7];
      ref_z = (r == 8'h00);
    end else if (ins[15:9] == 7'b0110100) begin
      ref_mem[ea] = 8'hFF;
    end
    it.w = ref_w; it.n = ref_n; it.z = ref_z; it.tag = tag;
    sb_q.push_back(it);
    w_before = wreg_o;
    instr_i = ins;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1;
      chk({tag, " R12 hold mid-cycle"}, 32'(wreg_o), 32'(w_before));
      if (coll && k == 2) begin
        ld_en_i = 1'b1; ld_addr_i = ea; ld_data_i = coll_d;
      end
    end
    @(posedge clk); #1;
    ld_en_i = 1'b0;
    instr_i = 16'h0000;
  endtask

  function automatic logic [15:0] rot(input logic d, input logic a, input logic [7:0] f);
    return {6'b010000, d, a, f};
  endfunction

  function automatic logic [15:0] fill(input logic a, input logic [7:0] f);
    return {7'b0110100, a, f};
  endfunction

  initial begin
    #(200000 * 20);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    ref_w = 8'h00; ref_n = 1'b0; ref_z = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R2 reset W", 32'(wreg_o), 32'h0);
    chk("R2 reset N", 32'(flag_n_o), 32'h0);
    chk("R2 reset Z", 32'(flag_z_o), 32'h0);
    chk("R1 reset phase", 32'(phase_o), 32'h0);
    @(negedge clk); rst_n = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      @(posedge clk); #1;
      chk("R1 phase step", 32'(phase_o), 32'(k % 4));
    end

    // rotate to W, access low window, bank ignored (R3 R4 R5 R8)
    bsr_i = 4'h3;
    load(12'h010, 8'hD7);
    issue(rot(1'b0, 1'b0, 8'h10), "R3 R8 rotate D7 to W");
    issue(rot(1'b0, 1'b0, 8'h10), "R4 d=0 leaves file");
    // rotate back to file (R4)
    issue(rot(1'b1, 1'b0, 8'h10), "R4 d=1 writes file");
    issue(rot(1'b0, 1'b0, 8'h10), "R4 file readback");
    // bank path (R7)
    load(12'h345, 8'h01);
    issue(rot(1'b0, 1'b1, 8'h45), "R7 bank path N");
    // access low with bank set, distinct byte (R8)
    load(12'h045, 8'h02);
    issue(rot(1'b0, 1'b0, 8'h45), "R8 access low ignores bsr");
    // access high window, zero result (R8 R5)
    load(12'hF80, 8'h00);
    issue(rot(1'b0, 1'b0, 8'h80), "R5 R8 access high zero");
    // extended mode paths (R9)
    ext_mode_i = 1'b1; ptr_i = 12'h200;
    load(12'h210, 8'h04);
    issue(rot(1'b0, 1'b0, 8'h10), "R9 indexed");
    load(12'h25F, 8'h03);
    issue(rot(1'b0, 1'b0, 8'h5F), "R9 indexed boundary 5F");
    load(12'hF60, 8'h10);
    issue(rot(1'b0, 1'b0, 8'h60), "R8 boundary 60 in ext mode");
    ptr_i = 12'hFF0;
    load(12'h00F, 8'h80);
    issue(rot(1'b0, 1'b0, 8'h1F), "R9 pointer wrap");
    load(12'h377, 8'h06);
    issue(rot(1'b0, 1'b1, 8'h77), "R7 bank path in ext mode");
    ext_mode_i = 1'b0;
    // fill keeps W and flags (R6): set Z first
    load(12'h0F1, 8'h00);
    issue(rot(1'b0, 1'b0, 8'hF1), "R5 Z before fill");
    bsr_i = 4'h1;
    load(12'h123, 8'h5A);
    issue(fill(1'b1, 8'h23), "R6 fill keeps W and flags");
    issue(rot(1'b0, 1'b1, 8'h23), "R6 fill readback");
    // unknown words (R10)
    load(12'h030, 8'h66);
    issue(16'h4430, "R10 unknown 4430");
    issue(16'h6A30, "R10 unknown 6A30");
    issue(16'h0000, "R10 unknown 0000");
    issue(rot(1'b0, 1'b0, 8'h30), "R10 memory untouched");
    // load vs commit collision (R11)
    load(12'h1AB, 8'h11);
    issue(fill(1'b1, 8'hAB), "R11 fill with colliding load", 1'b1, 8'h22);
    issue(rot(1'b0, 1'b1, 8'hAB), "R11 commit wins");
    load(12'h1AB, 8'h08);
    issue(rot(1'b0, 1'b1, 8'hAB), "R11 plain load");

    repeat (8) @(posedge clk);
    chk("R3 scoreboard drained", 32'(sb_q.size()), 32'h0);
    finish_run();
  end
endmodule